// File: doc/BRIEF.md
# PCI Type-0 Configuration Header Register File

This block holds the 64-byte type-0 configuration header of a single PCI function as a synthesizable register file. A local request port carries a byte offset, an access size in bytes, write data, and separate read and write strobes. Read data and an error flag are combinational responses to the request that is presented. A write takes effect at the next rising clock edge.

At reset every byte is loaded from parameters. These cover the identification and class codes, the command and status words, the interrupt routing bytes, six base address registers (BARs) with their decode sizes, and the expansion-ROM base. Only a small set of fields can be written, and each one only at specific access sizes. The write path also implements the sizing handshake that enumeration software uses. Writing all ones to a BAR returns its size mask and keeps the BAR's read-only type bits. The expansion-ROM base register has its own sizing pattern.

Top module: `cfg_hdr_regfile`

## Requirements
- R1: After reset, each header byte holds its parameter value, stored little-endian. The layout is: vendor ID at byte 0, device ID at 2, command at 4, status at 6, cache-line size at 0x0C, latency timer at 0x0D, BARs at 0x10 through 0x24, expansion ROM at 0x30, interrupt line at 0x3C, interrupt pin at 0x3D. Unassigned bytes read 0.
- R2: A read of 1, 2 or 4 bytes at any offset whose bytes all lie inside the header returns those bytes aligned to bit 0 and zero-extended, with the error flag low.
- R3: A read is flagged as an error, with read data 0, in either of two cases: its size is not 1, 2 or 4, or one of its bytes lies at offset 64 or beyond.
- R4: A 1-byte write is accepted only at 0x3C and 0x0C. At any other offset it raises the error flag and changes nothing.
- R5: A 2-byte write is accepted only at 0x04, 0x06 and 0x0C. At any other offset it raises the error flag and changes nothing.
- R6: A write of size 3, or of any size other than 1, 2 or 4, raises the error flag and changes no storage.
- R7: A 4-byte write at 0x04 updates only the 16-bit command field. The status word is unchanged.
- R8: A 4-byte write is accepted only at the six BAR offsets, at 0x30 and at 0x04. At any other offset it is rejected with the error flag.
- R9: Writing 0xFFFFFFFF to a BAR stores the inverse of (decode size − 1) in the writable bits. The read-only low bits keep their previous values. Bit 0 of the stored BAR selects the type: when it is 1 the BAR is I/O and bits 1:0 are read-only; when it is 0 the BAR is memory and bits 3:0 are read-only.
- R10: Any other write to a BAR stores the written value, with the read-only low bits (selected by bit 0 as in R9) kept at their stored values.
- R11: Writing 0xFFFFFFFE to the expansion-ROM base makes it read back 0xFFFFFFFF. Any other value written there is stored unchanged.
- R12: Reads and idle cycles never change the stored state. A request with both strobes high is flagged as an error and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset, loads the parameter image |
| req_rd_i | input | 1 | Read strobe |
| req_wr_i | input | 1 | Write strobe |
| req_off_i | input | 6 | Byte offset into the header |
| req_size_i | input | 3 | Access size in bytes (1, 2 or 4 legal) |
| req_wdata_i | input | 32 | Write data, aligned to bit 0 |
| rsp_rdata_o | output | 32 | Read data, zero-extended, 0 unless a legal read |
| rsp_err_o | output | 1 | Illegal access flag |

## Verification
The bench uses distinct nonzero identification, class, status and interrupt parameters, so that any byte placed in the wrong position shows up in a read. It configures BAR0 as I/O with a 256-byte decode and BAR1 as a prefetchable memory BAR with a 4 KiB decode, which brings both read-only-bit widths of the sizing and plain-write paths within reach. BAR3 keeps a zero size and so covers the degenerate sizing result. The remaining nonzero defaults are chosen so that a write leaking into a neighbouring field changes a value the bench reads back.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
  localparam int HDR_BYTES = 64;
  localparam int HDR_BITS  = HDR_BYTES * 8;
  localparam int OFF_W     = $clog2(HDR_BYTES);
  localparam int NUM_BARS  = 6;

  localparam logic [OFF_W-1:0] OFF_CMD     = 6'h04;
  localparam logic [OFF_W-1:0] OFF_STATUS  = 6'h06;
  localparam logic [OFF_W-1:0] OFF_CLS     = 6'h0C;
  localparam logic [OFF_W-1:0] OFF_BAR0    = 6'h10;
  localparam logic [OFF_W-1:0] OFF_BARLAST = 6'h24;
  localparam logic [OFF_W-1:0] OFF_ROM     = 6'h30;
  localparam logic [OFF_W-1:0] OFF_INTLINE = 6'h3C;

  typedef enum logic [1:0] {
    WK_PLAIN = 2'd0,
    WK_CMD32 = 2'd1,
    WK_BAR   = 2'd2,
    WK_ROM   = 2'd3
  } wr_kind_e;
endpackage

// File: rtl/cfg_access_decode.sv
module cfg_access_decode
  import cfg_hdr_pkg::*;
(
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [2:0]       size_i,
  output logic             err_o,
  output logic             rd_ok_o,
  output logic             wr_go_o,
  output wr_kind_e         wr_kind_o,
  output logic [2:0]       bar_idx_o,
  output logic [2:0]       wr_bytes_o
);
  logic [OFF_W:0] end_pos;
  logic           size_ok, in_range, wr_legal, bar_hit;

  assign end_pos  = {1'b0, off_i} + {{(OFF_W-2){1'b0}}, size_i};
  assign size_ok  = (size_i == 3'd1) || (size_i == 3'd2) || (size_i == 3'd4);
  assign in_range = end_pos <= (OFF_W+1)'(HDR_BYTES);
  assign bar_hit  = (off_i >= OFF_BAR0) && (off_i <= OFF_BARLAST) && (off_i[1:0] == 2'b00);

  logic [OFF_W-1:0] bar_rel;
  assign bar_rel   = off_i - OFF_BAR0;
  assign bar_idx_o = bar_rel[4:2];

  always_comb begin
    wr_legal   = 1'b0;
    wr_kind_o  = WK_PLAIN;
    wr_bytes_o = size_i;
    unique case (size_i)
      3'd1: wr_legal = (off_i == OFF_INTLINE) || (off_i == OFF_CLS);
      3'd2: wr_legal = (off_i == OFF_CMD) || (off_i == OFF_STATUS) || (off_i == OFF_CLS);
      3'd4: begin
        if (bar_hit) begin
          wr_legal  = 1'b1;
          wr_kind_o = WK_BAR;
        end else if (off_i == OFF_ROM) begin
          wr_legal  = 1'b1;
          wr_kind_o = WK_ROM;
        end else if (off_i == OFF_CMD) begin
          wr_legal   = 1'b1;
          wr_kind_o  = WK_CMD32;
          wr_bytes_o = 3'd2;  // only the command half lands
        end
      end
      default: wr_legal = 1'b0;
    endcase
  end

  always_comb begin
    err_o   = 1'b0;
    rd_ok_o = 1'b0;
    wr_go_o = 1'b0;
    if (rd_i && wr_i) begin
      err_o = 1'b1;
    end else if (rd_i) begin
      rd_ok_o = size_ok && in_range;
      err_o   = !rd_ok_o;
    end else if (wr_i) begin
      wr_go_o = wr_legal && in_range;
      err_o   = !wr_go_o;
    end
  end
endmodule

// File: rtl/cfg_bar_merge.sv
module cfg_bar_merge
  import cfg_hdr_pkg::*;
#(
  parameter logic [NUM_BARS*32-1:0] BAR_SIZES = '0
) (
  input  wr_kind_e    kind_i,
  input  logic [2:0]  bar_idx_i,
  input  logic [31:0] old_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] new_o
);
  localparam logic [31:0] ALL_ONES  = 32'hFFFF_FFFF;
  localparam logic [31:0] ROM_PROBE = 32'hFFFF_FFFE;
  localparam logic [31:0] RO_IO     = 32'h0000_0003;
  localparam logic [31:0] RO_MEM    = 32'h0000_000F;

  logic [31:0] size_tbl [NUM_BARS];
  for (genvar g = 0; g < NUM_BARS; g++) begin : g_size
    assign size_tbl[g] = BAR_SIZES[g*32 +: 32];
  end

  logic [31:0] sel_size, ro_mask, size_mask;
  always_comb begin
    sel_size = '0;
    for (int b = 0; b < NUM_BARS; b++)
      if (bar_idx_i == 3'(b)) sel_size = size_tbl[b];
  end

  assign ro_mask   = old_i[0] ? RO_IO : RO_MEM;
  assign size_mask = ~(sel_size - 32'd1);

  always_comb begin
    unique case (kind_i)
      WK_BAR:
        if (wdata_i == ALL_ONES) new_o = (size_mask & ~ro_mask) | (old_i & ro_mask);
        else                     new_o = (wdata_i & ~ro_mask) | (old_i & ro_mask);
      WK_ROM:  new_o = (wdata_i == ROM_PROBE) ? ALL_ONES : wdata_i;
      default: new_o = wdata_i;
    endcase
  end
endmodule

// File: rtl/cfg_byte_array.sv
module cfg_byte_array
  import cfg_hdr_pkg::*;
#(
  parameter int               DEPTH    = HDR_BYTES,
  parameter logic [DEPTH*8-1:0] INIT_IMG = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DEPTH-1:0]   we_i,
  input  logic [DEPTH*8-1:0] wd_i,
  output logic [DEPTH*8-1:0] img_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     img_o[g*8 +: 8] <= INIT_IMG[g*8 +: 8];
      else if (we_i[g]) img_o[g*8 +: 8] <= wd_i[g*8 +: 8];
    end
  end
endmodule

// File: rtl/cfg_hdr_regfile.sv
module cfg_hdr_regfile
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID   = 16'h0000,
  parameter logic [15:0] DEVICE_ID   = 16'h0000,
  parameter logic [15:0] CMD_INIT    = 16'h0000,
  parameter logic [15:0] STATUS_INIT = 16'h0000,
  parameter logic [7:0]  REV_ID      = 8'h00,
  parameter logic [7:0]  PROG_IF     = 8'h00,
  parameter logic [7:0]  SUB_CLASS   = 8'h00,
  parameter logic [7:0]  BASE_CLASS  = 8'h00,
  parameter logic [7:0]  CLS_INIT    = 8'h00,
  parameter logic [7:0]  LAT_INIT    = 8'h00,
  parameter logic [7:0]  HDR_TYPE    = 8'h00,
  parameter logic [7:0]  BIST_INIT   = 8'h00,
  parameter logic [NUM_BARS*32-1:0] BAR_INIT  = '0,
  parameter logic [NUM_BARS*32-1:0] BAR_SIZES = '0,
  parameter logic [31:0] CIS_PTR     = 32'h0,
  parameter logic [15:0] SUBSYS_VID  = 16'h0000,
  parameter logic [15:0] SUBSYS_ID   = 16'h0000,
  parameter logic [31:0] ROM_INIT    = 32'h0,
  parameter logic [7:0]  INT_LINE    = 8'h00,
  parameter logic [7:0]  INT_PIN     = 8'h00,
  parameter logic [7:0]  MIN_GNT     = 8'h00,
  parameter logic [7:0]  MAX_LAT     = 8'h00
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_rd_i,
  input  logic             req_wr_i,
  input  logic [OFF_W-1:0] req_off_i,
  input  logic [2:0]       req_size_i,
  input  logic [31:0]      req_wdata_i,
  output logic [31:0]      rsp_rdata_o,
  output logic             rsp_err_o
);
  function automatic logic [HDR_BITS-1:0] build_image();
    logic [HDR_BITS-1:0] m;
    m = '0;
    m[8*0  +: 16] = VENDOR_ID;
    m[8*2  +: 16] = DEVICE_ID;
    m[8*4  +: 16] = CMD_INIT;
    m[8*6  +: 16] = STATUS_INIT;
    m[8*8  +: 8]  = REV_ID;
    m[8*9  +: 8]  = PROG_IF;
    m[8*10 +: 8]  = SUB_CLASS;
    m[8*11 +: 8]  = BASE_CLASS;
    m[8*12 +: 8]  = CLS_INIT;
    m[8*13 +: 8]  = LAT_INIT;
    m[8*14 +: 8]  = HDR_TYPE;
    m[8*15 +: 8]  = BIST_INIT;
    for (int b = 0; b < NUM_BARS; b++) m[8*16 + 32*b +: 32] = BAR_INIT[32*b +: 32];
    m[8*40 +: 32] = CIS_PTR;
    m[8*44 +: 16] = SUBSYS_VID;
    m[8*46 +: 16] = SUBSYS_ID;
    m[8*48 +: 32] = ROM_INIT;
    m[8*60 +: 8]  = INT_LINE;
    m[8*61 +: 8]  = INT_PIN;
    m[8*62 +: 8]  = MIN_GNT;
    m[8*63 +: 8]  = MAX_LAT;
    return m;
  endfunction

  localparam logic [HDR_BITS-1:0] INIT_IMG = build_image();

  logic             rd_ok, wr_go;
  wr_kind_e         wr_kind;
  logic [2:0]       bar_idx, wr_bytes;
  logic [31:0]      window, new_word;
  logic [HDR_BYTES-1:0] byte_we;
  logic [HDR_BITS-1:0]  byte_wd, img;

  cfg_access_decode u_dec (
    .rd_i      (req_rd_i),
    .wr_i      (req_wr_i),
    .off_i     (req_off_i),
    .size_i    (req_size_i),
    .err_o     (rsp_err_o),
    .rd_ok_o   (rd_ok),
    .wr_go_o   (wr_go),
    .wr_kind_o (wr_kind),
    .bar_idx_o (bar_idx),
    .wr_bytes_o(wr_bytes)
  );

  // four-byte window starting at the offset, zero past the end
  always_comb begin
    for (int k = 0; k < 4; k++) begin
      logic [OFF_W:0] pos;
      pos = {1'b0, req_off_i} + (OFF_W+1)'(k);
      window[8*k +: 8] = (pos < (OFF_W+1)'(HDR_BYTES)) ? img[8*pos[OFF_W-1:0] +: 8] : 8'h00;
    end
  end

  cfg_bar_merge #(.BAR_SIZES(BAR_SIZES)) u_merge (
    .kind_i   (wr_kind),
    .bar_idx_i(bar_idx),
    .old_i    (window),
    .wdata_i  (req_wdata_i),
    .new_o    (new_word)
  );

  always_comb begin
    for (int i = 0; i < HDR_BYTES; i++) begin
      logic [OFF_W:0] rel;
      rel = (OFF_W+1)'(i) - {1'b0, req_off_i};
      byte_we[i]       = wr_go && (i >= int'(req_off_i)) && (rel < (OFF_W+1)'(wr_bytes));
      byte_wd[8*i +: 8] = new_word[8*rel[1:0] +: 8];
    end
  end

  cfg_byte_array #(.DEPTH(HDR_BYTES), .INIT_IMG(INIT_IMG)) u_arr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (byte_we),
    .wd_i  (byte_wd),
    .img_o (img)
  );

  always_comb begin
    rsp_rdata_o = '0;
    if (rd_ok) begin
      unique case (req_size_i)
        3'd1:    rsp_rdata_o = {24'h0, window[7:0]};
        3'd2:    rsp_rdata_o = {16'h0, window[15:0]};
        default: rsp_rdata_o = window;
      endcase
    end
  end
endmodule

module cfg_hdr_regfile_chk
  import cfg_hdr_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 rd_i,
  input logic                 wr_i,
  input logic [2:0]           size_i,
  input logic [31:0]          rdata_i,
  input logic                 err_i,
  input logic [HDR_BYTES-1:0] we_i,
  input logic [HDR_BITS-1:0]  img_i
);
  // R6
  size3_write_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rd_i && size_i == 3'd3) |-> err_i);
  // R6
  err_blocks_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |-> (we_i == '0));
  // R3
  err_rdata_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |-> (rdata_i == 32'h0));
  // R2
  byte_read_zext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && size_i == 3'd1 && !err_i) |-> (rdata_i[31:8] == 24'h0));
  // R12
  no_write_keeps_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(img_i));
  // R12
  dual_strobe_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && wr_i) |-> err_i);
endmodule

bind cfg_hdr_regfile cfg_hdr_regfile_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .rd_i   (req_rd_i),
  .wr_i   (req_wr_i),
  .size_i (req_size_i),
  .rdata_i(rsp_rdata_o),
  .err_i  (rsp_err_o),
  .we_i   (byte_we),
  .img_i  (img)
);

// File: tb/sim_cfg_hdr_regfile.sv
module sim_cfg_hdr_regfile;
  localparam int CLK_PERIOD = 10;

  localparam logic [15:0] P_VID  = 16'h1D5A;
  localparam logic [15:0] P_DID  = 16'h7711;
  localparam logic [15:0] P_STAT = 16'h0290;
  localparam logic [7:0]  P_CLS  = 8'h08;
  localparam logic [7:0]  P_LAT  = 8'h20;
  localparam logic [7:0]  P_HDR  = 8'h00;
  localparam logic [7:0]  P_BIST = 8'h00;
  localparam logic [7:0]  P_ILN  = 8'h0B;
  localparam logic [7:0]  P_IPN  = 8'h01;
  localparam logic [191:0] P_BARS = {32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_0008, 32'h0000_0001};
  localparam logic [191:0] P_SIZE = {32'h0, 32'h0, 32'h0, 32'h0001_0000, 32'h0000_1000, 32'h0000_0100};

  logic clk, rst_n, rd, wr, err;
  logic [5:0] off;
  logic [2:0] sz;
  logic [31:0] wd, rdat;
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  cfg_hdr_regfile #(
    .VENDOR_ID(P_VID), .DEVICE_ID(P_DID), .STATUS_INIT(P_STAT),
    .REV_ID(8'h03), .SUB_CLASS(8'h80), .BASE_CLASS(8'h02),
    .CLS_INIT(P_CLS), .LAT_INIT(P_LAT), .HDR_TYPE(P_HDR), .BIST_INIT(P_BIST),
    .BAR_INIT(P_BARS), .BAR_SIZES(P_SIZE), .SUBSYS_VID(16'h1D5A), .SUBSYS_ID(16'h0042),
    .ROM_INIT(32'h0), .INT_LINE(P_ILN), .INT_PIN(P_IPN), .MIN_GNT(8'h04), .MAX_LAT(8'h10)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_rd_i(rd), .req_wr_i(wr), .req_off_i(off),
    .req_size_i(sz), .req_wdata_i(wd), .rsp_rdata_o(rdat), .rsp_err_o(err)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic access(input logic r, input logic w, input logic [5:0] o, input logic [2:0] s,
                        input logic [31:0] d, output logic [31:0] q, output logic e);
    @(negedge clk);
    rd = r; wr = w; off = o; sz = s; wd = d;
    #(CLK_PERIOD/4);
    q = rdat; e = err;
    @(posedge clk);
    #1;
    rd = 0; wr = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] o, input logic [2:0] s,
                        input logic [31:0] exp, input logic exp_err);
    logic [31:0] q; logic e;
    access(1, 0, o, s, 32'h0, q, e);
    chk({tag, " data"}, q, exp);
    chk({tag, " err"}, {31'h0, e}, {31'h0, exp_err});
  endtask

  task automatic wr_chk(input string tag, input logic [5:0] o, input logic [2:0] s,
                        input logic [31:0] d, input logic exp_err);
    logic [31:0] q; logic e;
    access(0, 1, o, s, d, q, e);
    chk({tag, " err"}, {31'h0, e}, {31'h0, exp_err});
  endtask

  task automatic t_reset();
    rd_chk("R1 id word", 6'h00, 3'd4, {P_DID, P_VID}, 0);
    rd_chk("R1 status", 6'h06, 3'd2, {16'h0, P_STAT}, 0);
    rd_chk("R1 class word", 6'h08, 3'd4, 32'h0280_0003, 0);
    rd_chk("R1 irq word", 6'h3C, 3'd4, 32'h1004_010B, 0);
    rd_chk("R1 bar1", 6'h14, 3'd4, 32'h0000_0008, 0);
    rd_chk("R1 unused", 6'h34, 3'd4, 32'h0, 0);
  endtask

  task automatic t_reads();
    rd_chk("R2 byte1", 6'h01, 3'd1, {24'h0, P_VID[15:8]}, 0);
    rd_chk("R2 half unaligned", 6'h03, 3'd2, 32'h0000_0077, 0);
    rd_chk("R2 last byte", 6'h3F, 3'd1, 32'h0000_0010, 0);
    rd_chk("R3 size3", 6'h00, 3'd3, 32'h0, 1);
    rd_chk("R3 size0", 6'h00, 3'd0, 32'h0, 1);
    rd_chk("R3 past end", 6'h3E, 3'd4, 32'h0, 1);
  endtask

  task automatic t_byte_writes();
    wr_chk("R4 intline", 6'h3C, 3'd1, 32'h0000_0055, 0);
    rd_chk("R4 intline rb", 6'h3C, 3'd1, 32'h55, 0);
    wr_chk("R4 intpin ro", 6'h3D, 3'd1, 32'h0000_00EE, 1);
    rd_chk("R4 intpin kept", 6'h3D, 3'd1, {24'h0, P_IPN}, 0);
    wr_chk("R4 cls", 6'h0C, 3'd1, 32'h0000_0040, 0);
    rd_chk("R4 cls rb", 6'h0C, 3'd2, {16'h0, P_LAT, 8'h40}, 0);
  endtask

  task automatic t_half_writes();
    wr_chk("R5 cmd", 6'h04, 3'd2, 32'h0000_0147, 0);
    wr_chk("R5 status", 6'h06, 3'd2, 32'h0000_0230, 0);
    rd_chk("R5 cmd+status", 6'h04, 3'd4, 32'h0230_0147, 0);
    wr_chk("R5 vid ro", 6'h00, 3'd2, 32'h0000_BEEF, 1);
    rd_chk("R5 vid kept", 6'h00, 3'd2, {16'h0, P_VID}, 0);
    wr_chk("R5 cls half", 6'h0C, 3'd2, 32'h0000_2010, 0);
    rd_chk("R5 cls half rb", 6'h0C, 3'd4, {P_BIST, P_HDR, 16'h2010}, 0);
  endtask

  task automatic t_bad_size();
    wr_chk("R6 size3", 6'h3C, 3'd3, 32'h00FF_FFFF, 1);
    rd_chk("R6 unchanged", 6'h3C, 3'd4, 32'h1004_0155, 0);
    wr_chk("R6 size5", 6'h10, 3'd5, 32'hFFFF_FFFF, 1);
    rd_chk("R6 bar0 kept", 6'h10, 3'd4, 32'h0000_0001, 0);
  endtask

  task automatic t_word_cmd();
    wr_chk("R7 cmd32", 6'h04, 3'd4, 32'hABCD_0006, 0);
    rd_chk("R7 cmd only", 6'h04, 3'd4, 32'h0230_0006, 0);
    wr_chk("R8 word at 0", 6'h00, 3'd4, 32'h1234_5678, 1);
    wr_chk("R8 word at 8", 6'h08, 3'd4, 32'h1234_5678, 1);
    wr_chk("R8 word at 3C", 6'h3C, 3'd4, 32'h1234_5678, 1);
    rd_chk("R8 id kept", 6'h00, 3'd4, {P_DID, P_VID}, 0);
  endtask

  task automatic t_bar_size();
    wr_chk("R9 bar0 probe", 6'h10, 3'd4, 32'hFFFF_FFFF, 0);
    rd_chk("R9 io mask", 6'h10, 3'd4, 32'hFFFF_FF01, 0);
    wr_chk("R9 bar1 probe", 6'h14, 3'd4, 32'hFFFF_FFFF, 0);
    rd_chk("R9 mem mask", 6'h14, 3'd4, 32'hFFFF_F008, 0);
    wr_chk("R9 bar3 probe", 6'h1C, 3'd4, 32'hFFFF_FFFF, 0);
    rd_chk("R9 zero size", 6'h1C, 3'd4, 32'h0, 0);
  endtask

  task automatic t_bar_assign();
    wr_chk("R10 bar0 set", 6'h10, 3'd4, 32'h0000_C0F2, 0);
    rd_chk("R10 io low kept", 6'h10, 3'd4, 32'h0000_C0F1, 0);
    wr_chk("R10 bar1 set", 6'h14, 3'd4, 32'hE000_0007, 0);
    rd_chk("R10 mem low kept", 6'h14, 3'd4, 32'hE000_0008, 0);
    rd_chk("R10 bar2 untouched", 6'h18, 3'd4, 32'h0, 0);
  endtask

  task automatic t_rom();
    wr_chk("R11 rom probe", 6'h30, 3'd4, 32'hFFFF_FFFE, 0);
    rd_chk("R11 rom ones", 6'h30, 3'd4, 32'hFFFF_FFFF, 0);
    wr_chk("R11 rom set", 6'h30, 3'd4, 32'h000C_0001, 0);
    rd_chk("R11 rom rb", 6'h30, 3'd4, 32'h000C_0001, 0);
  endtask

  task automatic t_dual();
    logic [31:0] q; logic e;
    access(1, 1, 6'h3C, 3'd1, 32'h0000_0099, q, e);
    chk("R12 dual err", {31'h0, e}, 32'h1);
    chk("R12 dual rdata", q, 32'h0);
    rd_chk("R12 dual no write", 6'h3C, 3'd1, 32'h55, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rd = 0; wr = 0; off = '0; sz = '0; wd = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_reads();
    t_byte_writes();
    t_half_writes();
    t_bad_size();
    t_word_cmd();
    t_bar_size();
    t_bar_assign();
    t_rom();
    t_dual();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule